// File: doc/BRIEF.md
# Dual-Unit Watchdog Timer with Maskable Reload Sources

This block is a watchdog countdown timer that is set up through four byte-wide registers on a simple write and read port. A 16-bit counter is loaded from a programmed value. It counts down either once per incoming seconds tick or once per minute. The minute rate comes from an internal prescaler that divides the seconds tick. The time base itself is an input, and nothing in the block generates it.

Four single-cycle event strobes stand in for activity seen on peripheral buses: an infrared-controller data write, a mouse event, a keyboard event and a game-port read. Each strobe can be enabled or masked on its own. An enabled strobe reloads the running counter from the programmed value after a fixed settling delay.

When the counter runs out, or when software forces a timeout, the block does the following:
- It sets a sticky zero flag, which software clears by writing the control register.
- If enabled, it raises a one-cycle keyboard-reset pulse.
- It drives level outputs for a timeout signal and a power-good drop.

Top module: `wdog_dual_unit`

## Requirements
- R1: After reset, every register reads 0x00, the counter is 0, and all outputs are low (`irq_sel_o` is 0).
- R2: Register addresses are 0 control, 1 config, 2 value low byte and 3 value high byte. Config reads back as written. Control reads its source-enable bits in [7:4], zeros in [3:1] and the zero flag in bit 0.
- R3: A write to either value register loads the counter on the same clock edge with {high byte, low byte}, including the new byte. It also restarts the minute prescaler and cancels a pending reload. Writing a value of 0 stops the timer without setting the zero flag.
- R4: With config bit 7 = 1 (seconds), a running counter drops by one on each `sec_tick` pulse and holds otherwise.
- R5: With config bit 7 = 0 (minutes), the counter drops by one on every TICKS_PER_MIN-th `sec_tick`. The prescaler counts from the last value write or reload.
- R6: When a tick takes the counter from 1 to 0, control bit 0 (the zero flag) is set. A counter at 0 stays at 0 on further ticks.
- R7: `kbd_rst_o` is high for exactly one cycle, in the cycle after a timeout, when config bit 6 = 1. It stays low when config bit 6 = 0.
- R8: Control bits 7, 6, 5 and 4 enable the infrared, mouse, keyboard and game-port strobes as reload sources. A strobe whose enable bit is 0 has no effect.
- R9: An enabled strobe on a running counter reloads the programmed value exactly RELOAD_DLY cycles after the strobe's edge. Strobes arriving while a reload is pending are dropped. A stopped counter ignores strobes.
- R10: A control write with bit 0 = 0 clears the zero flag, and a control write with bit 0 = 1 leaves it unchanged. A timeout on the same edge as a clear wins, so the flag stays set.
- R11: A control write with bit 1 = 1 forces an immediate timeout: the counter goes to 0, the flag is set, and the reset pulse follows if it is enabled. Bit 1 always reads 0.
- R12: `tmo_o` equals flag AND config bit 5. `pwr_tmo_o` equals flag AND config bit 4. `irq_sel_o` equals config bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sec_tick | input | 1 | One-cycle seconds time-base pulse |
| ev_ir | input | 1 | Infrared-controller data-write strobe |
| ev_mouse | input | 1 | Mouse activity strobe |
| ev_kbd | input | 1 | Keyboard activity strobe |
| ev_game | input | 1 | Game-port read strobe |
| count_o | output | 16 | Current counter value |
| kbd_rst_o | output | 1 | One-cycle keyboard-reset pulse |
| tmo_o | output | 1 | Timeout level output |
| pwr_tmo_o | output | 1 | Power-good drop level output |
| irq_sel_o | output | 4 | Selected interrupt line |

## Verification
The bench builds the block with TICKS_PER_MIN = 3 and RELOAD_DLY = 4, instead of the 60-tick minute and the 5 ms settling delay of the defaults. With these values a minute rollover, a restart of the prescaler after a write or reload, and a strobe landing inside a pending reload window all occur within a few dozen cycles. The bench can therefore check each of them at the exact edge where the counter should change.

// File: rtl/wdu_pkg.sv
// Shared constants for the dual-unit watchdog: register addresses and
// the bit positions of control and config fields.
// Assumes byte-wide registers and a counter made of two of them.
package wdu_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int NSRC   = 4;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_VLO  = 2'd2,
        ADDR_VHI  = 2'd3
    } wdu_addr_e;

    // control register fields
    localparam int CTL_SRC_LSB = 4;
    localparam int CTL_FORCE   = 1;
    localparam int CTL_FLAG    = 0;
    // config register fields
    localparam int CFG_SECS    = 7;
    localparam int CFG_KRST    = 6;
    localparam int CFG_TMO     = 5;
    localparam int CFG_PWR     = 4;
    localparam int IRQ_W       = 4;
endpackage

// File: rtl/wdu_regs.sv
// Register file of the watchdog: control, config and the two value bytes.
// It produces value-write and force strobes for the counter and holds the
// sticky zero flag. Assumes one register access per cycle.
module wdu_regs
    import wdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout_hit,
    output logic [DATA_W-1:0] rdata,
    output logic [NSRC-1:0]   src_mask,
    output logic [DATA_W-1:0] cfg_q,
    output logic [CNT_W-1:0]  prog_val,
    output logic [CNT_W-1:0]  wr_val,
    output logic              val_wr,
    output logic              force_req,
    output logic              zero_flag
);
    wdu_addr_e         sel;
    logic [DATA_W-1:0] val_lo, val_hi;

    assign sel      = wdu_addr_e'(addr);
    assign prog_val = {val_hi, val_lo};

    // Decode write strobes and the value the counter takes on a value write
    always_comb begin
        val_wr    = wr_en && (sel == ADDR_VLO || sel == ADDR_VHI);
        force_req = wr_en && (sel == ADDR_CTRL) && wdata[CTL_FORCE];
        wr_val    = (sel == ADDR_VLO) ? {val_hi, wdata} : {wdata, val_lo};
    end

    // Hold the programmable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mask <= '0;
            cfg_q    <= '0;
            val_lo   <= '0;
            val_hi   <= '0;
        end else if (wr_en) begin
            case (sel)
                ADDR_CTRL: src_mask <= wdata[CTL_SRC_LSB +: NSRC];
                ADDR_CFG:  cfg_q    <= wdata;
                ADDR_VLO:  val_lo   <= wdata;
                ADDR_VHI:  val_hi   <= wdata;
                default:   ;
            endcase
        end
    end

    // Sticky zero flag: a timeout sets it, a control write with bit 0 low clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_flag <= 1'b0;
        else if (timeout_hit)
            zero_flag <= 1'b1;
        else if (wr_en && sel == ADDR_CTRL)
            zero_flag <= zero_flag & wdata[CTL_FLAG];
    end

    // Read multiplexer; the force bit and reserved bits read as zero
    always_comb begin
        case (sel)
            ADDR_CTRL: rdata = {src_mask, 3'b000, zero_flag};
            ADDR_CFG:  rdata = cfg_q;
            ADDR_VLO:  rdata = val_lo;
            default:   rdata = val_hi;
        endcase
    end
endmodule

// File: rtl/wdu_timebase.sv
// Time unit selection. In seconds mode every sec_tick is a unit tick. In
// minutes mode a prescaler passes every TICKS_PER_MIN-th sec_tick.
// The prescaler restarts on a counter load. Assumes TICKS_PER_MIN >= 2.
module wdu_timebase #(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic secs_mode,
    input  logic restart,
    output logic unit_tick
);
    localparam int PRE_W = $clog2(TICKS_PER_MIN);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MIN - 1);

    logic [PRE_W-1:0] pre_q;

    // Select the decrement strobe for the configured unit
    assign unit_tick = sec_tick && (secs_mode || pre_q == PRE_LAST);

    // Count seconds within the current minute
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pre_q <= '0;
        else if (sec_tick)
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wdu_reload.sv
// Reload path: masks the event strobes and arms a settling delay. When the
// delay runs out it fires the reload. Further strobes are dropped while a
// reload is pending. Assumes RELOAD_DLY >= 1.
module wdu_reload #(
    parameter int NSRC       = 4,
    parameter int RELOAD_DLY = 250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] src_mask,
    input  logic            running,
    input  logic            cancel,
    output logic            fire
);
    localparam int DLY_W = $clog2(RELOAD_DLY + 1);

    logic [NSRC-1:0]  src_hit;
    logic             pend_q;
    logic [DLY_W-1:0] dly_q;
    logic             arm;

    // Per-source masking of the event strobes
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = evt[i] & src_mask[i];
    end

    assign arm  = (|src_hit) && running && !pend_q;
    assign fire = pend_q && (dly_q == '0);

    // Pending-reload state and settling countdown
    always_ff @(posedge clk) begin
        if (!rst_n || cancel || fire) begin
            pend_q <= 1'b0;
            dly_q  <= '0;
        end else if (arm) begin
            pend_q <= 1'b1;
            dly_q  <= DLY_W'(RELOAD_DLY - 1);
        end else if (pend_q) begin
            dly_q  <= dly_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdu_count.sv
// Watchdog down-counter. Priority per edge: value write, forced timeout,
// reload, unit tick. It flags a timeout on a 1-to-0 step or a force and
// raises the keyboard-reset pulse one cycle later when that is enabled.
module wdu_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] prog_val,
    input  logic             force_req,
    input  logic             fire,
    input  logic             unit_tick,
    input  logic             krst_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             timeout_hit,
    output logic             kbd_rst
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Timeout event: a force, or a tick that reaches zero and is not overridden
    assign timeout_hit = !val_wr &&
                         (force_req || (!fire && unit_tick && cnt_q == ONE));

    // Counter update and reset-pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            kbd_rst <= 1'b0;
        end else begin
            kbd_rst <= timeout_hit && krst_en;
            if (val_wr)
                cnt_q <= wr_val;
            else if (force_req)
                cnt_q <= '0;
            else if (fire)
                cnt_q <= prog_val;
            else if (unit_tick && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_dual_unit.sv
// Top level of the dual-unit watchdog. It ties the register file, time
// base, reload path and counter together and derives the timeout level
// outputs. Assumes the bus event strobes are single-cycle pulses in clk.
module wdog_dual_unit
    import wdu_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60,
    parameter int RELOAD_DLY    = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sec_tick,
    input  logic              ev_ir,
    input  logic              ev_mouse,
    input  logic              ev_kbd,
    input  logic              ev_game,
    output logic [CNT_W-1:0]  count_o,
    output logic              kbd_rst_o,
    output logic              tmo_o,
    output logic              pwr_tmo_o,
    output logic [IRQ_W-1:0]  irq_sel_o
);
    logic [NSRC-1:0]   src_mask;
    logic [DATA_W-1:0] cfg_q;
    logic [CNT_W-1:0]  prog_val, wr_val, cnt_q;
    logic              val_wr, force_req, zero_flag;
    logic              timeout_hit, reload_fire, unit_tick;

    wdu_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .timeout_hit(timeout_hit), .rdata(reg_rdata),
        .src_mask(src_mask), .cfg_q(cfg_q), .prog_val(prog_val),
        .wr_val(wr_val), .val_wr(val_wr), .force_req(force_req),
        .zero_flag(zero_flag)
    );

    wdu_timebase #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_tb (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .secs_mode(cfg_q[CFG_SECS]), .restart(val_wr || reload_fire),
        .unit_tick(unit_tick)
    );

    wdu_reload #(.NSRC(NSRC), .RELOAD_DLY(RELOAD_DLY)) u_rld (
        .clk(clk), .rst_n(rst_n),
        .evt({ev_ir, ev_mouse, ev_kbd, ev_game}),
        .src_mask(src_mask), .running(cnt_q != '0),
        .cancel(val_wr || timeout_hit), .fire(reload_fire)
    );

    wdu_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .val_wr(val_wr), .wr_val(wr_val),
        .prog_val(prog_val), .force_req(force_req), .fire(reload_fire),
        .unit_tick(unit_tick), .krst_en(cfg_q[CFG_KRST]), .cnt_q(cnt_q),
        .timeout_hit(timeout_hit), .kbd_rst(kbd_rst_o)
    );

    // Level outputs follow the sticky flag gated by config
    assign count_o   = cnt_q;
    assign tmo_o     = zero_flag && cfg_q[CFG_TMO];
    assign pwr_tmo_o = zero_flag && cfg_q[CFG_PWR];
    assign irq_sel_o = cfg_q[IRQ_W-1:0];
endmodule

// File: rtl/wdu_chk.sv
// Property checker for the watchdog. It is bound to the top level and
// reads the counter, the flag and the internal strobes.
module wdu_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kbd_rst,
    input logic             flag,
    input logic             krst_en,
    input logic [CNT_W-1:0] cnt,
    input logic             val_wr,
    input logic             fire,
    input logic             force_req
);
    // R7
    kbd_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_rst |=> !kbd_rst);
    // R7
    kbd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_rst |-> $past(krst_en));
    // R6
    kbd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_rst |-> flag);
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !val_wr) |=> cnt == '0);
    // R4
    no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!val_wr && !fire) |=> cnt <= $past(cnt));
    // R11
    force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |=> (cnt == '0 && flag));
endmodule

bind wdog_dual_unit wdu_chk #(.CNT_W(wdu_pkg::CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .kbd_rst(kbd_rst_o), .flag(zero_flag),
    .krst_en(cfg_q[wdu_pkg::CFG_KRST]), .cnt(cnt_q), .val_wr(val_wr),
    .fire(reload_fire), .force_req(force_req)
);

// File: tb/wdog_dual_unit_tb_top.sv
// Scoreboard bench: driver tasks push expected items with a due cycle,
// and a monitor at each falling edge pops and compares them.
module wdog_dual_unit_tb_top;
    localparam int TPM = 3;
    localparam int RD  = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        sec_tick = 1'b0, ev_ir = 1'b0, ev_mouse = 1'b0;
    logic        ev_kbd = 1'b0, ev_game = 1'b0;
    logic [15:0] count_o;
    logic        kbd_rst_o, tmo_o, pwr_tmo_o;
    logic [3:0]  irq_sel_o;

    wdog_dual_unit #(.TICKS_PER_MIN(TPM), .RELOAD_DLY(RD)) dut_i (.*);

    always #10 clk = ~clk;

    typedef struct { int due; int sel; int exp; string req; } item_t;
    item_t sb_q[$];
    int    cyc = 0, checks = 0, errors = 0;
    bit    done = 1'b0;

    function automatic int observe(int sel);
        case (sel)
            0: return int'(count_o);
            1: return int'(reg_rdata);
            2: return int'(kbd_rst_o);
            3: return int'(tmo_o);
            4: return int'(pwr_tmo_o);
            default: return int'(irq_sel_o);
        endcase
    endfunction

    // Monitor: compare every item that falls due at this falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            int got;
            it  = sb_q.pop_front();
            got = observe(it.sel);
            checks = checks + 1;
            if (got != it.exp) begin
                errors = errors + 1;
                $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                         it.req, it.sel, got, it.exp);
            end
        end
    end

    // Driver helpers: each returns one time unit after a rising edge
    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic expect_now(int sel, int exp, string req);
        item_t it;
        it.due = cyc + 1; it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask
    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr_en = 1'b0; reg_addr = 2'd0;
    endtask
    task automatic rd(logic [1:0] a, int exp, string req);
        reg_addr = a;
        expect_now(1, exp, req);
        step(1);
        reg_addr = 2'd0;
    endtask
    task automatic tick(int n);
        repeat (n) begin sec_tick = 1'b1; step(1); sec_tick = 1'b0; end
    endtask
    task automatic evt(int which);
        ev_ir = (which == 3); ev_mouse = (which == 2);
        ev_kbd = (which == 1); ev_game = (which == 0);
        step(1);
        {ev_ir, ev_mouse, ev_kbd, ev_game} = 4'b0000;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_now(0, 0, "R1"); expect_now(2, 0, "R1");
        expect_now(3, 0, "R1"); expect_now(4, 0, "R1"); expect_now(5, 0, "R1");
        step(1);
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1");
        // R2 map and readback, R12 irq select, R10 bit0 high keeps flag low
        wr(1, 8'hF5); rd(1, 8'hF5, "R2"); expect_now(5, 5, "R12");
        wr(0, 8'h81); rd(0, 8'h80, "R2");
        // R3 value loads
        wr(2, 8'd5); expect_now(0, 5, "R3");
        wr(3, 8'd1); expect_now(0, 16'h0105, "R3");
        rd(2, 5, "R2"); rd(3, 1, "R2");
        wr(3, 8'd0); expect_now(0, 5, "R3");
        // R4 seconds counting
        tick(3); expect_now(0, 2, "R4");
        step(3); expect_now(0, 2, "R4");
        // R8 masked strobe ignored
        evt(2); step(RD + 1); expect_now(0, 2, "R8");
        // R9 delayed reload, second strobe while pending dropped
        evt(3); step(1); evt(3); step(1); expect_now(0, 2, "R9");
        step(1); expect_now(0, 5, "R9");
        tick(1); step(2); expect_now(0, 4, "R9");
        // R8 game-port only
        wr(0, 8'h10); tick(1);
        evt(3); step(RD + 1); expect_now(0, 3, "R8");
        evt(0); step(RD); expect_now(0, 5, "R8");
        // R6 R7 R12 timeout
        tick(4); expect_now(0, 1, "R4");
        tick(1); expect_now(0, 0, "R6"); expect_now(2, 1, "R7");
        expect_now(3, 1, "R12"); expect_now(4, 1, "R12");
        step(1); expect_now(2, 0, "R7");
        rd(0, 8'h11, "R6");
        tick(2); expect_now(0, 0, "R6");
        evt(0); step(RD + 1); expect_now(0, 0, "R9");
        // R10 flag clearing
        wr(0, 8'h11); rd(0, 8'h11, "R10");
        wr(0, 8'h10); rd(0, 8'h10, "R10"); expect_now(3, 0, "R10");
        // R7 no pulse when disabled
        wr(1, 8'hA0); wr(2, 8'd2); expect_now(0, 2, "R3");
        tick(2); expect_now(0, 0, "R6"); expect_now(2, 0, "R7");
        expect_now(3, 1, "R12"); expect_now(4, 0, "R12");
        step(1); expect_now(2, 0, "R7");
        rd(0, 8'h11, "R6"); wr(0, 8'h00);
        // R11 forced timeout
        wr(1, 8'hC0); wr(2, 8'd9); expect_now(0, 9, "R3");
        wr(0, 8'h02); expect_now(0, 0, "R11"); expect_now(2, 1, "R11");
        step(1); rd(0, 8'h01, "R11"); wr(0, 8'h00);
        // R5 minutes, prescaler restart on write
        wr(1, 8'h40); wr(2, 8'd2); expect_now(0, 2, "R5");
        tick(2); expect_now(0, 2, "R5");
        tick(1); expect_now(0, 1, "R5");
        tick(1); wr(2, 8'd3); tick(2); expect_now(0, 3, "R5");
        tick(1); expect_now(0, 2, "R5");
        // R5 prescaler restart on reload
        wr(0, 8'h20); tick(1);
        evt(1); step(RD); expect_now(0, 3, "R5");
        tick(2); expect_now(0, 3, "R5");
        tick(1); expect_now(0, 2, "R5");
        // R3 zero value stops without flag
        wr(2, 8'd0); expect_now(0, 0, "R3");
        step(1); rd(0, 8'h20, "R3");
        tick(4); expect_now(0, 0, "R3");
        step(2);
        if (sb_q.size() != 0) begin
            errors = errors + 1;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule